// File: doc/BRIEF.md
# Masked Read-Back Register Sequencer

This block answers processor reads on the single data port of a DMA controller. Each read strobe returns one byte. A 7-bit selection mask picks which bytes take part. The candidates are a live status byte and the low and high halves of three 16-bit counters: the transfer byte count, the source-side address counter and the destination-side address counter. Selected bytes always come back in a fixed order, and the sequence starts over after the last one. When no byte is selected, every read returns the live status byte.

The status byte is built afresh on every read. It has four constant bits, and the rest reflect:
- the transfer enable,
- a ready-mismatch indication, which counts only outside mode 1,
- the inverted pattern-match flag,
- the inverted end-of-block flag.

Three control strobes change the list:
- writing a new mask rebuilds the list from that mask;
- a status-only request forces the mask to select just the status byte;
- a restart strobe rewinds the sequence to its first entry without changing the mask.

Top module: `rdback_seq`

## Requirements
- R1: After reset, `rd_data` reads 0x38 and no byte is selected, so the first read returns the live status byte.
- R2: The status byte is 0xCC OR-ed with the following bits:
  - bit 0 = `xfer_en`;
  - bit 4 = NOT `match_hit`;
  - bit 5 = NOT `end_of_block`.
- R3: Status bit 1 is set only when `mode` is not 1 and `rdy_mismatch` is high.
- R4: Mask bit k selects entry k. The entries are:
  - 0: status;
  - 1: byte count [7:0];
  - 2: byte count [15:8];
  - 3: `addr_a_cnt` [7:0];
  - 4: `addr_a_cnt` [15:8];
  - 5: `addr_b_cnt` [7:0];
  - 6: `addr_b_cnt` [15:8].
  Selected entries are returned in ascending k.
- R5: Each read returns the current entry and advances to the next selected entry. After the highest selected entry, the next read returns the lowest selected entry. With one entry selected, every read returns that entry.
- R6: While the mask is zero, every read returns the live status byte.
- R7: A `stat_req` pulse sets the mask to 0x01 and rewinds the sequence, so later reads return only the status byte.
- R8: A `seq_init` pulse keeps the mask and rewinds the sequence, so the next read returns the lowest selected entry.
- R9: A `mask_wr` pulse loads `mask_data` and rewinds the sequence at once.
- R10: Counter and status bytes are sampled in the clock cycle of the read strobe, so each read reflects the input values present in that cycle.
- R11: `rd_data` updates one clock edge after a read strobe and holds its value while no read strobe is applied.
- R12: Two cases apply when strobes coincide:
  - A read in the same cycle as a list change is served from the old list. The sequence then restarts at the first entry of the new list.
  - Among the list-change strobes, `stat_req` takes priority over `mask_wr`, and `mask_wr` takes priority over `seq_init`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | One-cycle read strobe |
| mask_wr | input | 1 | Load a new selection mask |
| mask_data | input | 7 | Selection mask value |
| seq_init | input | 1 | Rewind the sequence using the current mask |
| stat_req | input | 1 | Select the status byte only and rewind |
| xfer_en | input | 1 | Transfer enable state |
| mode | input | 2 | Operating mode |
| rdy_mismatch | input | 1 | Ready level disagrees with the programmed polarity |
| match_hit | input | 1 | Pattern-match flag |
| end_of_block | input | 1 | End-of-block flag |
| byte_cnt | input | 16 | Transfer byte count |
| addr_a_cnt | input | 16 | Source-side address counter |
| addr_b_cnt | input | 16 | Destination-side address counter |
| rd_data | output | 8 | Byte returned by the last read |

## Verification
The hardest situation to reach is a read that lands in the same cycle as a list change. The returned byte must come from the old list position, while the sequence must continue from the first entry of the new list. The stimulus gets there in two steps:
1. It advances part-way through a multi-entry mask.
2. It raises the read strobe together with `seq_init`, and in a second case together with both `stat_req` and `mask_wr`.

The scoreboard then checks the byte from the shared cycle and the bytes from the reads that follow. Between reads the stimulus also changes the counters, which shows that each returned byte is sampled in its own read cycle and not when the list was rebuilt.

// File: rtl/rdback_pkg.sv
package rdback_pkg;
  localparam int NSEL  = 7;
  localparam int SEL_W = 3;
  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [NSEL-1:0]  selmask_t;

  // Lowest selected entry; zero when nothing is selected.
  function automatic sel_t lowest_sel(input selmask_t m);
    sel_t r;
    r = '0;
    for (int i = NSEL - 1; i >= 0; i--) begin
      if (m[i]) r = sel_t'(i);
    end
    return r;
  endfunction

  // Next selected entry after p, wrapping; p itself when it is the only one.
  function automatic sel_t after_sel(input selmask_t m, input sel_t p);
    sel_t r;
    int   idx;
    r = p;
    for (int k = NSEL - 1; k >= 1; k--) begin
      idx = (int'(p) + k) % NSEL;
      if (m[idx]) r = sel_t'(idx);
    end
    return r;
  endfunction
endpackage

// File: rtl/rdback_status.sv
module rdback_status (
  input  logic       xfer_en,
  input  logic [1:0] mode,
  input  logic       rdy_mismatch,
  input  logic       match_hit,
  input  logic       end_of_block,
  output logic [7:0] status
);
  localparam logic [7:0] STAT_BASE = 8'hCC;
  localparam logic [1:0] MODE_NO_RDY = 2'd1;

  always_comb begin
    status    = STAT_BASE;
    status[0] = xfer_en;
    status[1] = (mode != MODE_NO_RDY) && rdy_mismatch;
    status[4] = ~match_hit;
    status[5] = ~end_of_block;
  end
endmodule

// File: rtl/rdback_bytesel.sv
module rdback_bytesel
  import rdback_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  sel_t             sel,
  input  logic [7:0]       status,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic [CNT_W-1:0] addr_a_cnt,
  input  logic [CNT_W-1:0] addr_b_cnt,
  output logic [7:0]       dout
);
  localparam int NCNT  = 3;
  localparam int BPC   = CNT_W / 8;

  logic [CNT_W-1:0] cnts [NCNT];
  logic [7:0]       ent  [NSEL];

  assign cnts[0] = byte_cnt;
  assign cnts[1] = addr_a_cnt;
  assign cnts[2] = addr_b_cnt;
  assign ent[0]  = status;

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    for (genvar h = 0; h < BPC; h++) begin : g_half
      assign ent[1 + g*BPC + h] = cnts[g][8*h +: 8];
    end
  end

  always_comb begin
    dout = 8'h00;
    if (int'(sel) < NSEL) dout = ent[sel];
  end
endmodule

// File: rtl/rdback_listptr.sv
module rdback_listptr
  import rdback_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rd_stb,
  input  logic     mask_wr,
  input  selmask_t mask_data,
  input  logic     seq_init,
  input  logic     stat_req,
  output selmask_t mask_q,
  output sel_t     ptr_q,
  output logic     list_empty
);
  selmask_t mask_n;
  sel_t     ptr_n;
  logic     mask_en, ptr_en;

  assign list_empty = (mask_q == '0);

  always_comb begin
    mask_n  = mask_q;
    ptr_n   = ptr_q;
    mask_en = 1'b0;
    ptr_en  = 1'b0;
    if (stat_req) begin
      mask_n  = selmask_t'(1);
      ptr_n   = '0;
      mask_en = 1'b1;
      ptr_en  = 1'b1;
    end else if (mask_wr) begin
      mask_n  = mask_data;
      ptr_n   = lowest_sel(mask_data);
      mask_en = 1'b1;
      ptr_en  = 1'b1;
    end else if (seq_init) begin
      ptr_n   = lowest_sel(mask_q);
      ptr_en  = 1'b1;
    end else if (rd_stb && !list_empty) begin
      ptr_n   = after_sel(mask_q, ptr_q);
      ptr_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ptr_q  <= '0;
    end else begin
      if (mask_en) mask_q <= mask_n;
      if (ptr_en)  ptr_q  <= ptr_n;
    end
  end

  assert_ptr_on_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !list_empty |-> mask_q[ptr_q]);

  assert_single_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(mask_q) == 1 && rd_stb && !stat_req && !mask_wr && !seq_init)
      |=> $stable(ptr_q));

  assert_stat_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_req |=> (mask_q == selmask_t'(1)) && (ptr_q == '0));

  assert_mask_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !stat_req) |=> mask_q == $past(mask_data));
endmodule

// File: rtl/rdback_seq.sv
module rdback_seq
  import rdback_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_stb,
  input  logic             mask_wr,
  input  logic [6:0]       mask_data,
  input  logic             seq_init,
  input  logic             stat_req,
  input  logic             xfer_en,
  input  logic [1:0]       mode,
  input  logic             rdy_mismatch,
  input  logic             match_hit,
  input  logic             end_of_block,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic [CNT_W-1:0] addr_a_cnt,
  input  logic [CNT_W-1:0] addr_b_cnt,
  output logic [7:0]       rd_data
);
  localparam logic [7:0] RD_RESET = 8'h38;

  logic [1:0] rst_sync;
  logic       rst_i;
  selmask_t   mask_q;
  sel_t       ptr_q;
  logic       list_empty;
  logic [7:0] live_status, entry_byte, rd_data_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  rdback_status u_status (
    .xfer_en      (xfer_en),
    .mode         (mode),
    .rdy_mismatch (rdy_mismatch),
    .match_hit    (match_hit),
    .end_of_block (end_of_block),
    .status       (live_status)
  );

  rdback_listptr u_list (
    .clk        (clk),
    .rst_n      (rst_i),
    .rd_stb     (rd_stb),
    .mask_wr    (mask_wr),
    .mask_data  (mask_data),
    .seq_init   (seq_init),
    .stat_req   (stat_req),
    .mask_q     (mask_q),
    .ptr_q      (ptr_q),
    .list_empty (list_empty)
  );

  rdback_bytesel #(.CNT_W(CNT_W)) u_sel (
    .sel        (ptr_q),
    .status     (live_status),
    .byte_cnt   (byte_cnt),
    .addr_a_cnt (addr_a_cnt),
    .addr_b_cnt (addr_b_cnt),
    .dout       (entry_byte)
  );

  always_comb begin
    rd_data_n = list_empty ? live_status : entry_byte;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)      rd_data <= RD_RESET;
    else if (rd_stb) rd_data <= rd_data_n;
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_i)
    !rd_stb |=> $stable(rd_data));

  assert_empty_live_R6: assert property (@(posedge clk) disable iff (!rst_i)
    (rd_stb && list_empty) |=> rd_data == $past(live_status));
endmodule

// File: tb/rdback_seq_bench.sv
`timescale 1ns/1ps
module rdback_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_stb = 1'b0, mask_wr = 1'b0, seq_init = 1'b0, stat_req = 1'b0;
  logic [6:0]  mask_data = '0;
  logic        xfer_en = 1'b0, rdy_mismatch = 1'b0, match_hit = 1'b0, end_of_block = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [15:0] byte_cnt = '0, addr_a_cnt = '0, addr_b_cnt = '0;
  logic [7:0]  rd_data;

  int checks = 0, errors = 0;
  bit done = 0;
  bit pend = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  logic [6:0] m_mask = '0;
  int         m_list[$];
  int         m_pos = 0;

  always #2.5 clk = ~clk;

  rdback_seq u_rdback_seq (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .mask_wr(mask_wr), .mask_data(mask_data),
    .seq_init(seq_init), .stat_req(stat_req), .xfer_en(xfer_en), .mode(mode),
    .rdy_mismatch(rdy_mismatch), .match_hit(match_hit), .end_of_block(end_of_block),
    .byte_cnt(byte_cnt), .addr_a_cnt(addr_a_cnt), .addr_b_cnt(addr_b_cnt), .rd_data(rd_data)
  );

  function automatic logic [7:0] m_status();
    logic [7:0] s;
    s = 8'hCC;
    if (xfer_en) s = s | 8'h01;
    if (mode != 2'd1 && rdy_mismatch) s = s | 8'h02;
    if (!match_hit) s = s | 8'h10;
    if (!end_of_block) s = s | 8'h20;
    return s;
  endfunction

  function automatic logic [7:0] m_entry(input int k);
    case (k)
      0: return m_status();
      1: return byte_cnt[7:0];
      2: return byte_cnt[15:8];
      3: return addr_a_cnt[7:0];
      4: return addr_a_cnt[15:8];
      5: return addr_b_cnt[7:0];
      default: return addr_b_cnt[15:8];
    endcase
  endfunction

  task automatic m_rebuild();
    m_list.delete();
    for (int i = 0; i < 7; i++) if (m_mask[i]) m_list.push_back(i);
    m_pos = 0;
  endtask

  function automatic logic [7:0] m_read();
    logic [7:0] v;
    if (m_list.size() == 0) return m_status();
    v = m_entry(m_list[m_pos]);
    m_pos = (m_pos + 1) % m_list.size();
    return v;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Driver: one read, expected value pushed for the monitor.
  task automatic do_read(input string tag);
    @(negedge clk);
    rd_stb = 1'b1;
    exp_q.push_back(m_read());
    tag_q.push_back(tag);
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic wr_mask(input logic [6:0] m);
    @(negedge clk);
    mask_wr = 1'b1; mask_data = m;
    m_mask = m; m_rebuild();
    @(negedge clk);
    mask_wr = 1'b0;
  endtask

  task automatic pulse_init();
    @(negedge clk); seq_init = 1'b1; m_rebuild();
    @(negedge clk); seq_init = 1'b0;
  endtask

  task automatic pulse_stat();
    @(negedge clk); stat_req = 1'b1; m_mask = 7'h01; m_rebuild();
    @(negedge clk); stat_req = 1'b0;
  endtask

  // Monitor: compare one cycle after each read strobe.
  always @(posedge clk) pend <= rd_stb;
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) check("scoreboard underflow", rd_data, 8'hxx);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset value", rd_data, 8'h38);
    xfer_en = 1; match_hit = 1; end_of_block = 0; mode = 2'd0; rdy_mismatch = 1;
    do_read("R1 empty after reset");
    xfer_en = 0; match_hit = 0; end_of_block = 1; rdy_mismatch = 0;
    do_read("R2 status flags");
    mode = 2'd1; rdy_mismatch = 1;
    do_read("R3 mode1 masks mismatch");
    mode = 2'd2;
    do_read("R3 mode2 shows mismatch");
    do_read("R6 empty repeat");
    byte_cnt = 16'h1234; addr_a_cnt = 16'h5678; addr_b_cnt = 16'h9ABC;
    wr_mask(7'h7F);
    for (int i = 0; i < 9; i++) do_read("R4 R5 R9 full order wrap");
    wr_mask(7'h2A);
    for (int i = 0; i < 4; i++) begin
      byte_cnt = byte_cnt + 16'h0101; addr_a_cnt = addr_a_cnt - 16'h0011;
      do_read("R10 live counter sample");
    end
    pulse_init();
    do_read("R8 restart first entry");
    do_read("R8 second entry");
    @(negedge clk); held = rd_data;
    byte_cnt = 16'hFFFF; addr_b_cnt = 16'h0000; xfer_en = 1;
    repeat (3) @(negedge clk);
    check("R11 hold without read", rd_data, held);
    pulse_stat();
    do_read("R7 status only");
    do_read("R7 status only repeat");
    wr_mask(7'h40);
    do_read("R5 single entry");
    do_read("R5 single entry repeat");
    wr_mask(7'h18);
    do_read("R12 prep");
    // read coinciding with restart: old position served, then first entry
    @(negedge clk);
    rd_stb = 1; seq_init = 1;
    exp_q.push_back(m_read()); tag_q.push_back("R12 read with restart");
    m_rebuild();
    @(negedge clk); rd_stb = 0; seq_init = 0;
    do_read("R12 after restart");
    // stat_req wins over mask_wr in the same cycle
    @(negedge clk);
    rd_stb = 1; stat_req = 1; mask_wr = 1; mask_data = 7'h06;
    exp_q.push_back(m_read()); tag_q.push_back("R12 read with status request");
    m_mask = 7'h01; m_rebuild();
    @(negedge clk); rd_stb = 0; stat_req = 0; mask_wr = 0;
    do_read("R12 status wins priority");
    do_read("R12 status wins repeat");
    wr_mask(7'h00);
    do_read("R6 cleared mask");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule